// File: doc/BRIEF.md
# Boundary-Splitting Descriptor List Builder

This block turns a stream of scatter-gather segments, each a start address and a byte length, into a table of fixed-size descriptors that a DMA engine can walk. A segment that runs across a 64 KiB address boundary is cut into pieces, so that no single descriptor reaches past such a boundary. Each descriptor is written out as one 128-bit entry made of four 32-bit words, each word stored in big-endian byte order. The final entry of a table carries an end-of-list flag.

Segments arrive over a valid/ready handshake, and a last marker closes the list. The block makes one descriptor per clock cycle. It holds the newest descriptor back by one step, so the end flag can be set on it once the list is known to be finished, and no write ever has to be repeated. The table has a fixed capacity. If a list needs more entries than that, the block stops writing, consumes the rest of the list, and raises an overflow pulse in place of the done pulse. The requester then falls back to programmed I/O for that request.

Top module: `sg_desc_builder`

## Requirements
- R1: A descriptor covers min(65536 - A[15:0], remaining) bytes, where A is the current address, so no descriptor crosses a 64 KiB boundary.
- R2: The descriptors of a list cover every segment exactly, in input order. Each descriptor starts where the one before it ended. Entries are written to indices 0, 1, 2 and so on.
- R3: The length field holds only the low 16 bits of the descriptor's byte count, so a full 64 KiB piece is written with length 0.
- R4: Let be(w) be the 32-bit word w with its byte order reversed. The layout of wr_data is as follows. [31:0] is zero. [63:32] is be(address). [95:64] is zero. [127:96] is be(F). In F, bit 31 is the end flag, bits 30:16 are zero and bits 15:0 are the length.
- R5: The end flag is set on the final entry of a list that completes, and on no other entry.
- R6: A list may hold up to MAX_ENTRIES entries. When a further entry would be needed, the block makes no more writes. When the list's last segment has been consumed, overflow pulses for one cycle with count 0 and done stays low.
- R7: A segment of length zero ends the table. The segments after it, up to the one marked last, are accepted and ignored. If the zero-length segment comes first, the block writes nothing and done pulses with count 0.
- R8: When a list completes, done pulses for exactly one cycle with count equal to the number of entries written. The final write occurs in that same cycle.
- R9: seg_ready stays low while a segment is being split. A segment of k pieces holds seg_ready low for k cycles after it is accepted.
- R10: After reset, seg_ready is high and wr_en, done and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | A segment is offered |
| seg_ready | output | 1 | The block accepts the offered segment |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | This segment closes the list |
| wr_en | output | 1 | Descriptor write strobe |
| wr_idx | output | IDX_W | Table index of the entry being written |
| wr_data | output | 128 | Descriptor entry contents |
| done | output | 1 | One-cycle pulse when a list completes |
| count | output | CNT_W | Entry count, valid while done is high |
| overflow | output | 1 | One-cycle pulse when a list exceeded capacity |

## Verification
Several properties are checked on every cycle. No written entry crosses a boundary. The end flag appears only together with done, and done with a non-zero count always comes with the final write at index count-1. Overflow never carries a count or a write, no index goes past capacity, and accepting a non-empty segment drops seg_ready on the next cycle. Other behaviour can only be shown by the bench's scenarios. These include exact coverage of each segment in order, the length-0 encoding of full 64 KiB pieces, cut-off at a zero-length segment, and the exact point where a list tips into overflow. The bench shows them by sweeping start offsets and lengths around the boundary and comparing whole tables against arithmetic.

// File: rtl/sg_desc_builder.sv
`timescale 1ns/1ps
module sg_desc_builder #(
  parameter int MAX_ENTRIES = 256,
  parameter int LEN_W       = 32,
  parameter int BOUND_W     = 16,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [127:0]     wr_data,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam int CHK_W = BOUND_W + 1;

  typedef enum logic [1:0] {S_IN, S_SPLIT, S_DRAIN, S_FIN} state_t;

  state_t             st;
  logic [31:0]        cur_addr, pend_addr;
  logic [LEN_W-1:0]   rem;
  logic               seg_is_last, pend_vld, abort;
  logic [BOUND_W-1:0] pend_len;
  logic [CNT_W-1:0]   n;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  wire [CHK_W-1:0] span = {1'b1, {BOUND_W{1'b0}}} - {1'b0, cur_addr[BOUND_W-1:0]};
  wire             fits  = rem <= LEN_W'(span);
  wire [CHK_W-1:0] chunk = fits ? rem[CHK_W-1:0] : span;
  wire             full  = (n == CNT_W'(MAX_ENTRIES));
  wire             eol   = (st == S_FIN);
  wire [31:0]      flw   = {eol, {(31-BOUND_W){1'b0}}, pend_len};

  assign seg_ready = (st == S_IN) || (st == S_DRAIN);
  assign wr_en     = pend_vld && (((st == S_SPLIT) && !full) || ((st == S_FIN) && !abort));
  assign wr_idx    = IDX_W'(n - CNT_W'(1));
  assign wr_data   = {bswap(flw), 32'h0, bswap(pend_addr), 32'h0};
  assign done      = (st == S_FIN) && !abort;
  assign overflow  = (st == S_FIN) && abort;
  assign count     = done ? n : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IN;
      n           <= '0;
      pend_vld    <= 1'b0;
      abort       <= 1'b0;
      cur_addr    <= '0;
      rem         <= '0;
      seg_is_last <= 1'b0;
      pend_addr   <= '0;
      pend_len    <= '0;
    end else begin
      case (st)
        S_IN: if (seg_valid) begin
          if (seg_len == '0) begin
            st <= seg_last ? S_FIN : S_DRAIN;
          end else begin
            cur_addr    <= seg_addr;
            rem         <= seg_len;
            seg_is_last <= seg_last;
            st          <= S_SPLIT;
          end
        end
        S_SPLIT: begin
          if (full) begin
            abort <= 1'b1;
            st    <= seg_is_last ? S_FIN : S_DRAIN;
          end else begin
            pend_vld  <= 1'b1;
            pend_addr <= cur_addr;
            pend_len  <= chunk[BOUND_W-1:0];
            n         <= n + CNT_W'(1);
            cur_addr  <= cur_addr + 32'(chunk);
            rem       <= rem - LEN_W'(chunk);
            if (fits) st <= seg_is_last ? S_FIN : S_IN;
          end
        end
        S_DRAIN: if (seg_valid && seg_last) st <= S_FIN;
        default: begin
          n        <= '0;
          pend_vld <= 1'b0;
          abort    <= 1'b0;
          st       <= S_IN;
        end
      endcase
    end
  end

  wire [31:0]      dec_addr = bswap(wr_data[63:32]);
  wire [31:0]      dec_flw  = bswap(wr_data[127:96]);
  wire [CHK_W-1:0] dec_len  = (dec_flw[BOUND_W-1:0] == '0) ? {1'b1, {BOUND_W{1'b0}}}
                                                            : {1'b0, dec_flw[BOUND_W-1:0]};

  p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, dec_addr[BOUND_W-1:0]} + {1'b0, dec_len}) <= {2'b01, {BOUND_W{1'b0}}});

  p_eol_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec_flw[31]) |-> done);

  p_done_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && count != '0) |-> (wr_en && dec_flw[31] && wr_idx == IDX_W'(count - CNT_W'(1))));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (count == '0 && !wr_en && !done));

  p_idx_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < 32'(MAX_ENTRIES)));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && seg_len != '0 && st == S_IN) |=> !seg_ready);
endmodule

// File: tb/sg_desc_builder_bench.sv
`timescale 1ns/1ps
module sg_desc_builder_bench;
  localparam int MAXB = 8;
  localparam int IW   = 3;
  localparam int CW   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, seg_valid, seg_ready, seg_last;
  logic [31:0]   seg_addr, seg_len;
  logic          wr_en, done, overflow;
  logic [IW-1:0] wr_idx;
  logic [127:0]  wr_data;
  logic [CW-1:0] count;

  sg_desc_builder #(.MAX_ENTRIES(MAXB), .LEN_W(32), .BOUND_W(16)) u_sg_desc_builder (
    .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .done(done), .count(count), .overflow(overflow));

  int total = 0, bad = 0;
  int wcnt, ndone, novf, rcount, last_wait;
  logic [127:0] tbl [0:MAXB-1];
  longint sa [0:15];
  longint sl [0:15];
  int nseg;
  longint ea [0:MAXB];
  longint el [0:MAXB];

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      tbl[wr_idx] = wr_data;
      wcnt++;
    end
    if (done) begin ndone++; rcount = int'(count); end
    if (overflow) novf++;
  end

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_list();
    int n = 0;
    bit ovf = 0, stop = 0;
    for (int s = 0; s < nseg; s++) begin
      longint a = sa[s], r = sl[s];
      if (stop || ovf) continue;
      if (r == 0) begin stop = 1; continue; end
      while (r > 0) begin
        longint c = 65536 - (a & 64'hFFFF);
        if (n == MAXB) begin ovf = 1; break; end
        if (c > r) c = r;
        ea[n] = a; el[n] = c; n++;
        a += c; r -= c;
      end
    end
    wcnt = 0; ndone = 0; novf = 0; rcount = -1;
    for (int s = 0; s < nseg; s++) begin
      @(negedge clk);
      seg_valid = 1'b1; seg_addr = 32'(sa[s]); seg_len = 32'(sl[s]); seg_last = (s == nseg - 1);
      last_wait = 0;
      #1;
      while (!seg_ready) begin last_wait++; @(negedge clk); #1; end
    end
    @(negedge clk);
    seg_valid = 1'b0; seg_last = 1'b0;
    for (int w = 0; w < 2000 && (ndone + novf) == 0; w++) @(negedge clk);
    @(negedge clk); @(negedge clk);
    if (ovf) begin
      chk(novf == 1 && ndone == 0, "R6", "overflow pulse", novf, 1);
    end else begin
      chk(ndone == 1 && novf == 0, "R8", "done pulse", ndone, 1);
      chk(rcount == n, "R8", "count", rcount, n);
      chk(wcnt == n, "R7", "writes", wcnt, n);
      for (int e = 0; e < n && e < wcnt; e++) begin
        logic [31:0] f = bsw(tbl[e][127:96]);
        logic [31:0] ef = {(e == n - 1), 15'h0, 16'(el[e])};
        chk(bsw(tbl[e][63:32]) == 32'(ea[e]), "R2", "addr", bsw(tbl[e][63:32]), ea[e]);
        chk(f[15:0] == 16'(el[e]), "R3", "len field", f[15:0], el[e] & 64'hFFFF);
        chk((ea[e] & 64'hFFFF) + el[e] <= 65536, "R1", "boundary", (ea[e] & 64'hFFFF) + el[e], 65536);
        chk(f[31] == (e == n - 1), "R5", "eol", f[31], e == n - 1);
        chk(tbl[e] == {bsw(ef), 32'h0, bsw(32'(ea[e])), 32'h0}, "R4", "entry", tbl[e][127:96], bsw(ef));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint offs [0:4];
    longint lens [0:10];
    offs = '{0, 1, 64'h7FFF, 64'hFFFF, 64'hFFF0};
    lens = '{1, 2, 64'hF, 64'h10, 64'h7FFF, 64'hFFFF, 64'h10000, 64'h10001, 64'h1FFFF, 64'h20000, 64'h2FFFF};
    rst_n = 1'b0; seg_valid = 1'b0; seg_addr = '0; seg_len = '0; seg_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg_ready && !wr_en && !done && !overflow, "R10", "reset state",
        {seg_ready, wr_en, done, overflow}, 4'b1000);

    for (int o = 0; o < 5; o++)
      for (int l = 0; l < 11; l++) begin
        nseg = 1; sa[0] = 64'h1234_0000 + offs[o]; sl[0] = lens[l];
        run_list();
      end

    nseg = 3;
    sa[0] = 64'h0000_FF00; sl[0] = 64'h300;
    sa[1] = 64'h00A0_0010; sl[1] = 64'h10;
    sa[2] = 64'h0BCD_8000; sl[2] = 64'h18000;
    run_list();

    nseg = 2; sa[0] = 0; sl[0] = 64'h30000; sa[1] = 64'h500; sl[1] = 4;
    run_list();
    chk(last_wait == 3, "R9", "ready low cycles", last_wait, 3);

    nseg = 1; sa[0] = 64'h100; sl[0] = 0;
    run_list();
    chk(rcount == 0 && wcnt == 0, "R7", "empty first", rcount, 0);

    nseg = 3; sa[0] = 64'h2000; sl[0] = 64'h40; sa[1] = 64'h9000; sl[1] = 0;
    sa[2] = 64'h7000; sl[2] = 64'h20;
    run_list();
    chk(rcount == 1, "R7", "cut at zero seg", rcount, 1);

    for (int k = 8; k <= 9; k++) begin
      nseg = k;
      for (int s = 0; s < k; s++) begin sa[s] = longint'(s) << 20; sl[s] = 64'h10000; end
      run_list();
      chk((k == 8) ? (ndone == 1) : (novf == 1), "R6", "capacity edge", k, 8);
    end

    nseg = 1; sa[0] = 64'h0040_0000; sl[0] = 64'h80000;
    run_list();
    nseg = 2; sa[0] = 64'h0040_0000; sl[0] = 64'h80001; sa[1] = 64'h10; sl[1] = 4;
    run_list();
    chk(novf == 1 && rcount == -1, "R6", "overflow no done", novf, 1);

    nseg = 1; sa[0] = 64'hFFFF; sl[0] = 2;
    run_list();
    chk(rcount == 2, "R2", "recovery after overflow", rcount, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule